// File: doc/BRIEF.md
# System Reset Sequencer

This block merges four reset requests into a single CPU reset and a peripheral register reset. The four requests are a main power-on reset, a fine power-on reset, an external reset pin and a watchdog reset. All sequencing runs on a slow low-power clock. After a request goes away, the block waits a number of slow-clock cycles that depends on the request before it lets the CPU out of reset. The final release reaches the CPU clock domain through a reset synchronizer.

The block also controls the enable of the fast main oscillator. Power-type requests switch the oscillator off while they are held. The sequencer makes sure the oscillator has been running for at least one full slow cycle before the release. A small status register records which kind of reset happened last, and software can clear or update that register with a write strobe.

The main power-on reset (`por_main_n`, active low) acts as the asynchronous reset of the whole slow-clock domain. The other requests are active-high levels. The external pin is resynchronized inside the block. The fine power-on and watchdog requests are taken as already timed to the slow clock.

Top module: `sysrst_sequencer`

## Requirements
- R1: After `por_main_n` rises, `periph_rst` falls on the 512th rising edge of `clk_slow`. While `por_main_n` is low, `periph_rst`, `trim_rst` and `cpu_rst` are 1 and `mosc_en` is 0.
- R2: After `por_fine` drops, the countdown is 1 cycle. Because the oscillator must first run for one full cycle, `periph_rst` falls on the 2nd slow edge after the drop.
- R3: `ext_rst_pin` passes through two slow-clock flops and then counts 8 cycles, so `periph_rst` falls on the 10th slow edge after the pin drops.
- R4: After `wdog_rst` drops, `periph_rst` falls on the 1st slow edge, provided the oscillator was already running.
- R5: `mosc_en` is 0 while `por_fine` or the synchronized external pin is asserted. A watchdog request leaves `mosc_en` at 1.
- R6: `mosc_en` is 1 for the whole slow cycle before `periph_rst` falls, and it stays 1 while released.
- R7: A main power-on, fine power-on or external reset sets `stat_pwr` and clears both `stat_wdog` and `stat_ramdis`. `stat_pwr` and `stat_wdog` are never both 1.
- R8: A watchdog reset sets `stat_wdog`, clears `stat_pwr` and leaves `stat_ramdis` unchanged.
- R9: `trim_rst` follows the reset for main power-on, external and watchdog requests. A reset caused by `por_fine` alone leaves `trim_rst` at 0.
- R10: Requests are ranked main power-on, then fine power-on, then external, then watchdog. A higher-ranked request during a countdown restarts it with its own count. A lower-ranked request is ignored and changes neither the timing nor the status.
- R11: A one-cycle `stat_wr` applies `stat_wdata` as follows: bit 0 set clears `stat_pwr`, bit 1 set clears `stat_wdog`, and bit 2 is loaded into `stat_ramdis`. A reset event on the same slow edge takes precedence and the write is lost.
- R12: `cpu_rst` rises as soon as `periph_rst` rises. It falls on the 2nd rising edge of `clk_cpu` after `periph_rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow sequencing clock |
| clk_cpu | input | 1 | CPU clock |
| por_main_n | input | 1 | Main power-on reset, active low, asynchronous |
| por_fine | input | 1 | Fine power-on reset request, slow-clock timed |
| ext_rst_pin | input | 1 | External reset pin, asynchronous |
| wdog_rst | input | 1 | Watchdog reset request, slow-clock timed |
| stat_wr | input | 1 | Status write strobe, slow-clock timed |
| stat_wdata | input | 3 | Status write data (see R11) |
| cpu_rst | output | 1 | CPU reset, active high, CPU-clock released |
| periph_rst | output | 1 | Peripheral register reset, active high |
| trim_rst | output | 1 | Reset for the reference trim register |
| mosc_en | output | 1 | Main oscillator enable |
| stat_pwr | output | 1 | Power-on reset cause flag |
| stat_wdog | output | 1 | Watchdog reset cause flag |
| stat_ramdis | output | 1 | RAM-disable flag |

## Verification
Two things can land on the same slow edge: a software write to the status register and a reset event that rewrites the cause flags. The bench provokes this by raising `stat_wr` and a reset request on the same slow-clock low phase. It then checks that the flags match the event's rule and not the written data, for both a watchdog event and a power-type event. A second kind of collision is a higher-ranked or lower-ranked request arriving in the middle of a countdown. The bench judges this by the exact slow-edge count to release.

// File: rtl/sysrst_seq_pkg.sv
package sysrst_seq_pkg;

  // Ranking follows the numeric value: larger wins.
  typedef enum logic [1:0] {
    SRC_WDOG = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_FINE = 2'd2,
    SRC_MAIN = 2'd3
  } rst_src_e;

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sysrst_countdown.sv
module sysrst_countdown
  import sysrst_seq_pkg::*;
#(
  parameter int DLY_MAIN = 512,
  parameter int DLY_FINE = 1,
  parameter int DLY_EXT  = 8,
  parameter int DLY_WDOG = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fine_i,
  input  logic     ext_i,
  input  logic     wdog_i,
  output logic     rel_o,
  output logic     mosc_en_o,
  output logic     trim_rst_o,
  output logic     ev_o,
  output rst_src_e ev_src_o
);

  localparam int DLY_MAX = (DLY_MAIN > DLY_EXT) ? DLY_MAIN : DLY_EXT;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  rst_src_e         src_q, src_d;
  logic             rel_q, rel_d;
  logic             osc_q, osc_d;
  logic             trim_q, trim_d;
  logic             req_any;
  rst_src_e         req_src;
  logic             accept;

  function automatic logic [CNT_W-1:0] dly_of(rst_src_e s);
    case (s)
      SRC_MAIN: dly_of = CNT_W'(DLY_MAIN);
      SRC_FINE: dly_of = CNT_W'(DLY_FINE);
      SRC_EXT:  dly_of = CNT_W'(DLY_EXT);
      default:  dly_of = CNT_W'(DLY_WDOG);
    endcase
  endfunction

  always_comb begin
    req_any = fine_i | ext_i | wdog_i;
    if (fine_i)     req_src = SRC_FINE;
    else if (ext_i) req_src = SRC_EXT;
    else            req_src = SRC_WDOG;
    accept = req_any && (rel_q || (req_src >= src_q));
  end

  always_comb begin
    cnt_d  = cnt_q;
    src_d  = src_q;
    rel_d  = rel_q;
    trim_d = trim_q;
    osc_d  = ~(fine_i | ext_i);
    if (accept) begin
      src_d  = req_src;
      cnt_d  = dly_of(req_src);
      rel_d  = 1'b0;
      trim_d = (req_src != SRC_FINE) | (trim_q & ~rel_q);
    end else if (!rel_q) begin
      if (cnt_q > CNT_W'(1)) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (osc_q) begin
        rel_d  = 1'b1;
        trim_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(DLY_MAIN);
      src_q  <= SRC_MAIN;
      rel_q  <= 1'b0;
      osc_q  <= 1'b0;
      trim_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      src_q  <= src_d;
      rel_q  <= rel_d;
      osc_q  <= osc_d;
      trim_q <= trim_d;
    end
  end

  assign rel_o      = rel_q;
  assign mosc_en_o  = osc_q;
  assign trim_rst_o = trim_q;
  assign ev_o       = accept;
  assign ev_src_o   = req_src;

  AST_OSC_LEADS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> $past(osc_q)); // R6
  AST_RELEASED_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> osc_q); // R6
  AST_LOWER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_q && src_q == SRC_EXT && wdog_i && !fine_i && !ext_i) |=> (src_q == SRC_EXT && !rel_q)); // R10

endmodule

// File: rtl/sysrst_status.sv
module sysrst_status
  import sysrst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_i,
  input  rst_src_e   ev_src_i,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  output logic       pwr_o,
  output logic       wdog_o,
  output logic       ramdis_o
);

  logic pwr_q, pwr_d;
  logic wdog_q, wdog_d;
  logic ram_q, ram_d;

  always_comb begin
    pwr_d  = pwr_q;
    wdog_d = wdog_q;
    ram_d  = ram_q;
    if (ev_i) begin
      if (ev_src_i == SRC_WDOG) begin
        wdog_d = 1'b1;
        pwr_d  = 1'b0;
      end else begin
        pwr_d  = 1'b1;
        wdog_d = 1'b0;
        ram_d  = 1'b0;
      end
    end else if (wr_i) begin
      pwr_d  = pwr_q & ~wdata_i[0];
      wdog_d = wdog_q & ~wdata_i[1];
      ram_d  = wdata_i[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b1;
      wdog_q <= 1'b0;
      ram_q  <= 1'b0;
    end else begin
      pwr_q  <= pwr_d;
      wdog_q <= wdog_d;
      ram_q  <= ram_d;
    end
  end

  assign pwr_o    = pwr_q;
  assign wdog_o   = wdog_q;
  assign ramdis_o = ram_q;

  AST_CAUSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwr_q, wdog_q})); // R7
  AST_WDOG_KEEPS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && ev_src_i == SRC_WDOG) |=> $stable(ram_q)); // R8
  AST_EVENT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && wr_i) |=> (pwr_q | wdog_q)); // R11

endmodule

// File: rtl/sysrst_sequencer.sv
module sysrst_sequencer
  import sysrst_seq_pkg::*;
#(
  parameter int DLY_MAIN   = 512,
  parameter int DLY_FINE   = 1,
  parameter int DLY_EXT    = 8,
  parameter int DLY_WDOG   = 1,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk_slow,
  input  logic       clk_cpu,
  input  logic       por_main_n,
  input  logic       por_fine,
  input  logic       ext_rst_pin,
  input  logic       wdog_rst,
  input  logic       stat_wr,
  input  logic [2:0] stat_wdata,
  output logic       cpu_rst,
  output logic       periph_rst,
  output logic       trim_rst,
  output logic       mosc_en,
  output logic       stat_pwr,
  output logic       stat_wdog,
  output logic       stat_ramdis
);

  logic     ext_s;
  logic     rel;
  logic     ev;
  rst_src_e ev_src;
  logic     cpu_run;

  sysrst_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_ext_sync (
    .clk   (clk_slow),
    .rst_n (por_main_n),
    .d_i   (ext_rst_pin),
    .q_o   (ext_s)
  );

  sysrst_countdown #(
    .DLY_MAIN (DLY_MAIN),
    .DLY_FINE (DLY_FINE),
    .DLY_EXT  (DLY_EXT),
    .DLY_WDOG (DLY_WDOG)
  ) u_countdown (
    .clk        (clk_slow),
    .rst_n      (por_main_n),
    .fine_i     (por_fine),
    .ext_i      (ext_s),
    .wdog_i     (wdog_rst),
    .rel_o      (rel),
    .mosc_en_o  (mosc_en),
    .trim_rst_o (trim_rst),
    .ev_o       (ev),
    .ev_src_o   (ev_src)
  );

  sysrst_status u_status (
    .clk      (clk_slow),
    .rst_n    (por_main_n),
    .ev_i     (ev),
    .ev_src_i (ev_src),
    .wr_i     (stat_wr),
    .wdata_i  (stat_wdata),
    .pwr_o    (stat_pwr),
    .wdog_o   (stat_wdog),
    .ramdis_o (stat_ramdis)
  );

  // Assert at once with the slow-domain reset, release after SYNC_DEPTH CPU edges.
  sysrst_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_cpu_sync (
    .clk   (clk_cpu),
    .rst_n (rel),
    .d_i   (1'b1),
    .q_o   (cpu_run)
  );

  assign periph_rst = ~rel;
  assign cpu_rst    = ~cpu_run;

endmodule

// File: tb/sysrst_sequencer_bench.sv
module sysrst_sequencer_bench;

  logic       clk_slow = 1'b0;
  logic       clk_cpu  = 1'b0;
  logic       por_main_n, por_fine, ext_rst_pin, wdog_rst, stat_wr;
  logic [2:0] stat_wdata;
  logic       cpu_rst, periph_rst, trim_rst, mosc_en, stat_pwr, stat_wdog, stat_ramdis;

  int checks = 0;
  int errors = 0;
  bit m_pwr, m_wdog, m_ram;

  localparam int D_MAIN = 512;
  localparam int D_FINE = 1;
  localparam int D_EXT  = 8;
  localparam int D_WDOG = 1;

  sysrst_sequencer u_sysrst_sequencer (
    .clk_slow, .clk_cpu, .por_main_n, .por_fine, .ext_rst_pin, .wdog_rst,
    .stat_wr, .stat_wdata, .cpu_rst, .periph_rst, .trim_rst, .mosc_en,
    .stat_pwr, .stat_wdog, .stat_ramdis
  );

  initial forever #4 clk_cpu = ~clk_cpu;
  initial begin
    #2;
    forever #20 clk_slow = ~clk_slow;
  end

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_slow);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (periph_rst && n < 2000);
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: por_fine    = v;
      1: ext_rst_pin = v;
      default: wdog_rst = v;
    endcase
  endtask

  function automatic int exp_rel(input int s);
    case (s)
      0: exp_rel = D_FINE + ((D_FINE < 2) ? 1 : 0);
      1: exp_rel = D_EXT + 2;
      default: exp_rel = D_WDOG;
    endcase
  endfunction

  task automatic chk_status(input string tag);
    chk(stat_pwr == m_pwr, {tag, " stat_pwr"}, stat_pwr, m_pwr);
    chk(stat_wdog == m_wdog, {tag, " stat_wdog"}, stat_wdog, m_wdog);
    chk(stat_ramdis == m_ram, {tag, " stat_ramdis"}, stat_ramdis, m_ram);
  endtask

  task automatic model_event(input int s);
    if (s == 2) begin
      m_wdog = 1'b1; m_pwr = 1'b0;
    end else begin
      m_pwr = 1'b1; m_wdog = 1'b0; m_ram = 1'b0;
    end
  endtask

  task automatic do_write(input logic [2:0] w);
    stat_wr = 1'b1; stat_wdata = w;
    tick();
    stat_wr = 1'b0;
    m_pwr  = m_pwr & ~w[0];
    m_wdog = m_wdog & ~w[1];
    m_ram  = w[2];
    chk_status("R11 write");
  endtask

  task automatic pulse(input int s);
    int n;
    set_src(s, 1'b1);
    tick(4);
    chk(periph_rst == 1'b1, "R2/R3/R4 held periph_rst", periph_rst, 1);
    chk(cpu_rst == 1'b1, "R12 held cpu_rst", cpu_rst, 1);
    chk(mosc_en == (s == 2), "R5 held mosc_en", mosc_en, (s == 2));
    chk(trim_rst == (s != 0), "R9 held trim_rst", trim_rst, (s != 0));
    set_src(s, 1'b0);
    measure(n);
    chk(n == exp_rel(s), "R2/R3/R4 release edge", n, exp_rel(s));
    chk(mosc_en == 1'b1, "R6 mosc_en at release", mosc_en, 1);
    chk(cpu_rst == 1'b0, "R12 cpu_rst released", cpu_rst, 0);
    chk(trim_rst == 1'b0, "R9 trim_rst released", trim_rst, 0);
    model_event(s);
    chk_status(s == 2 ? "R8 event" : "R7 event");
  endtask

  initial begin
    int n;
    por_main_n = 1'b0; por_fine = 1'b0; ext_rst_pin = 1'b0; wdog_rst = 1'b0;
    stat_wr = 1'b0; stat_wdata = 3'b000;
    m_pwr = 1'b1; m_wdog = 1'b0; m_ram = 1'b0;
    tick(3);
    chk(periph_rst == 1'b1, "R1 reset periph_rst", periph_rst, 1);
    chk(cpu_rst == 1'b1, "R1 reset cpu_rst", cpu_rst, 1);
    chk(trim_rst == 1'b1, "R1 reset trim_rst", trim_rst, 1);
    chk(mosc_en == 1'b0, "R1 reset mosc_en", mosc_en, 0);
    chk_status("R7 reset");

    // R1: main power-on release count
    por_main_n = 1'b1;
    tick();
    chk(mosc_en == 1'b1 && periph_rst, "R6 osc before release", mosc_en, 1);
    measure(n);
    chk(n + 1 == D_MAIN, "R1 release edge", n + 1, D_MAIN);

    // R12: precise CPU-side release after a watchdog reset
    wdog_rst = 1'b1;
    tick();
    wdog_rst = 1'b0;
    @(negedge periph_rst);
    @(posedge clk_cpu); #1;
    chk(cpu_rst == 1'b1, "R12 first cpu edge", cpu_rst, 1);
    @(posedge clk_cpu); #1;
    chk(cpu_rst == 1'b0, "R12 second cpu edge", cpu_rst, 0);
    tick();
    model_event(2);
    chk_status("R8 wdog");

    // Sweep: every source against every write pattern
    for (int s = 0; s < 3; s++) begin
      for (int w = 0; w < 8; w++) begin
        do_write(3'(w));
        pulse(s);
      end
    end

    // R10: fine preempts an external countdown
    ext_rst_pin = 1'b1; tick(4); ext_rst_pin = 1'b0;
    tick(4);
    por_fine = 1'b1; tick();
    chk(mosc_en == 1'b0 && trim_rst == 1'b1, "R10 preempt state", {mosc_en, trim_rst}, 1);
    por_fine = 1'b0;
    measure(n);
    chk(n == exp_rel(0), "R10 preempt restart", n, exp_rel(0));
    model_event(1);
    chk_status("R10 preempt");

    // R10: watchdog during an external countdown is ignored
    do_write(3'b100);
    ext_rst_pin = 1'b1; tick(4); ext_rst_pin = 1'b0;
    tick(4);
    wdog_rst = 1'b1; tick(); wdog_rst = 1'b0;
    measure(n);
    chk(n + 5 == exp_rel(1), "R10 lower ignored timing", n + 5, exp_rel(1));
    model_event(1);
    chk_status("R10 lower ignored");

    // R11: event on the same edge as a write wins
    do_write(3'b100);
    wdog_rst = 1'b1; stat_wr = 1'b1; stat_wdata = 3'b010;
    tick();
    wdog_rst = 1'b0; stat_wr = 1'b0;
    measure(n);
    model_event(2);
    chk_status("R11 wdog beats write");
    por_fine = 1'b1; stat_wr = 1'b1; stat_wdata = 3'b101;
    tick();
    por_fine = 1'b0; stat_wr = 1'b0;
    measure(n);
    model_event(0);
    chk_status("R11 fine beats write");

    // R1: main power-on in the middle of operation
    do_write(3'b100);
    por_main_n = 1'b0; tick();
    m_pwr = 1'b1; m_wdog = 1'b0; m_ram = 1'b0;
    chk(mosc_en == 1'b0 && periph_rst && cpu_rst, "R1 mid-run reset", mosc_en, 0);
    chk_status("R7 mid-run");
    por_main_n = 1'b1;
    measure(n);
    chk(n == D_MAIN, "R1 mid-run release", n, D_MAIN);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule